// File: doc/BRIEF.md
# Fixed-Period Pulse Delay Line with Coincidence Gate

This block delays a one-bit detector pulse stream by a fixed number of clock cycles so that it can be compared against a second, undelayed detector channel. Both raw inputs are asynchronous to the system clock. Each one first passes through a two-flop synchronizer. After that, a pulse exists only as the level seen at rising clock edges.

The delayed channel is written into a circular single-clock dual-port memory, one sample per clock, without ever stopping. The same address is read on every cycle before it is overwritten, so each bit comes back out one full lap later. The live channel is re-timed by one register so that the two channels line up. A coincidence output is the AND of the delayed bit and the aligned live bit. A saturating counter counts the low-to-high transitions of that output.

The lap length `DELAY` is a parameter. A 2 ms laser period on a 50 MHz clock needs `DELAY = 100000`, which is set at instantiation. The default stays small, and simulation uses a short lap.

Top module: `period_delay_coinc`

## Requirements
- R1: While `rst` is high at a rising edge, `delayedOut`, `delayedValid`, `coincOut` and `coincCount` are all 0 after that edge.
- R2: A level on `delayChIn` sampled at rising edge k appears on `delayedOut` after edge k+DELAY+2, provided `delayedValid` is high then.
- R3: After edge n, `coincOut` equals the `delayChIn` level sampled at edge n-2-DELAY ANDed with the `liveChIn` level sampled at edge n-2. The two channels are therefore exactly DELAY samples apart.
- R4: The memory is written at every cycle and its address wraps from DELAY-1 to 0 indefinitely. R2 continues to hold after many wraps.
- R5: Counting the first rising edge with `rst` low as edge 1, `delayedValid` is low after edges 1..DELAY and high from edge DELAY+1 onward until the next reset.
- R6: While `delayedValid` is low, `delayedOut` and `coincOut` are 0 whatever the inputs.
- R7: If `coincOut` is 1 in a cycle and was 0 in the cycle before, `coincCount` increases by exactly 1 after the following edge. Otherwise it does not change.
- R8: `coincCount` saturates at 2^COUNT_W-1 and does not wrap.
- R9: `coincClr` high at a rising edge sets `coincCount` to 0 after that edge. This takes priority over an increment.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| delayChIn | input | 1 | Raw asynchronous pulse input of the channel to be delayed |
| liveChIn | input | 1 | Raw asynchronous pulse input of the live channel |
| coincClr | input | 1 | Synchronous clear of the coincidence counter |
| delayedOut | output | 1 | Delayed channel bit, gated by validity |
| delayedValid | output | 1 | High once the memory holds a full lap of samples |
| coincOut | output | 1 | Delayed bit AND aligned live bit |
| coincCount | output | COUNT_W | Saturating count of coincidence rising edges |

## Verification
A `delayChIn` level captured at edge k is due on `delayedOut` after edge k+DELAY+2. A `liveChIn` level captured at the same edge reaches the coincidence gate after edge k+2. The valid flag rises after edge DELAY+1. A counter update lands one edge after the coincidence rise or clear that caused it. The bench drives inputs at the falling edge and samples a quarter period after each rising edge. On each cycle it pops one queued expected sample per channel, so each comparison falls exactly on the cycle in which the result is due. The live stream is partly built from the delayed stream of DELAY samples earlier, so that a shift of even one cycle in either path breaks many expected coincidences.

// File: rtl/delay_line_pkg.sv
package delay_line_pkg;

  // Synchronizer depth shared by both channels keeps their alignment.
  localparam int SYNC_STAGES = 2;

  // Channel positions in the packed raw-input vector.
  localparam int CH_DELAY = 0;
  localparam int CH_LIVE  = 1;
  localparam int NUM_CH   = 2;

  // Strobes from control to datapath.
  typedef struct packed {
    logic wrEn;      // store the current synchronized sample
    logic rdEn;      // fetch the sample one lap old
    logic outValid;  // memory holds a full lap of real samples
  } lineStrobes_t;

endpackage

// File: rtl/delay_sync.sv
module delay_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic asyncIn,
  output logic syncOut
);

  logic [STAGES-1:0] stageQ;

  always_ff @(posedge clk) begin
    if (rst) stageQ <= '0;
    else     stageQ <= {stageQ[STAGES-2:0], asyncIn};
  end

  assign syncOut = stageQ[STAGES-1];

endmodule

// File: rtl/delay_ctrl.sv
module delay_ctrl
  import delay_line_pkg::*;
#(
  parameter int DELAY = 2048
) (
  input  logic                clk,
  input  logic                rst,
  output logic [$clog2(DELAY)-1:0] ptr,
  output lineStrobes_t        strobes
);

  localparam int PTR_W  = $clog2(DELAY);
  localparam int FILL_W = $clog2(DELAY + 1) + 1;
  localparam logic [PTR_W-1:0]  PTR_LAST = PTR_W'(DELAY - 1);
  localparam logic [FILL_W-1:0] FILL_END = FILL_W'(DELAY);

  logic [PTR_W-1:0]  ptrQ;
  logic [FILL_W-1:0] fillCnt;
  logic              primedQ;

  // Shared address: read-before-write at the same slot gives one lap of delay.
  always_ff @(posedge clk) begin
    if (rst)                   ptrQ <= '0;
    else if (ptrQ == PTR_LAST) ptrQ <= '0;
    else                       ptrQ <= ptrQ + 1'b1;
  end

  // Counts writes since reset until one full lap has been stored.
  always_ff @(posedge clk) begin
    if (rst) begin
      fillCnt <= '0;
      primedQ <= 1'b0;
    end else if (!primedQ) begin
      fillCnt <= fillCnt + 1'b1;
      if (fillCnt == FILL_END) primedQ <= 1'b1;
    end
  end

  assign ptr              = ptrQ;
  assign strobes.wrEn     = !rst;
  assign strobes.rdEn     = !rst;
  assign strobes.outValid = primedQ;

endmodule

// File: rtl/delay_datapath.sv
module delay_datapath
  import delay_line_pkg::*;
#(
  parameter int DELAY   = 2048,
  parameter int COUNT_W = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM_CH-1:0]        rawIn,
  input  logic [$clog2(DELAY)-1:0] ptr,
  input  lineStrobes_t             strobes,
  input  logic                     coincClr,
  output logic                     delayedOut,
  output logic                     coincOut,
  output logic [COUNT_W-1:0]       coincCount
);

  localparam logic [COUNT_W-1:0] COUNT_MAX = {COUNT_W{1'b1}};

  logic [NUM_CH-1:0] syncBits;

  // One synchronizer per channel, identical depth.
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_sync
    delay_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk     (clk),
      .rst     (rst),
      .asyncIn (rawIn[ch]),
      .syncOut (syncBits[ch])
    );
  end

  // Circular lap memory, no reset on the array.
  logic lapMem [DELAY];
  logic rdData;

  always_ff @(posedge clk) begin
    if (strobes.rdEn) rdData <= lapMem[ptr];
    if (strobes.wrEn) lapMem[ptr] <= syncBits[CH_DELAY];
  end

  // Live channel matched to the one-cycle write/read stage.
  logic liveAligned;

  always_ff @(posedge clk) begin
    if (rst) liveAligned <= 1'b0;
    else     liveAligned <= syncBits[CH_LIVE];
  end

  assign delayedOut = strobes.outValid & rdData;
  assign coincOut   = delayedOut & liveAligned;

  // Rising-edge counter with saturation and priority clear.
  logic                coincPrev;
  logic [COUNT_W-1:0]  countQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      coincPrev <= 1'b0;
      countQ    <= '0;
    end else begin
      coincPrev <= coincOut;
      if (coincClr)
        countQ <= '0;
      else if (coincOut && !coincPrev && countQ != COUNT_MAX)
        countQ <= countQ + 1'b1;
    end
  end

  assign coincCount = countQ;

endmodule

// File: rtl/period_delay_coinc.sv
module period_delay_coinc
  import delay_line_pkg::*;
#(
  parameter int DELAY   = 2048,
  parameter int COUNT_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               delayChIn,
  input  logic               liveChIn,
  input  logic               coincClr,
  output logic               delayedOut,
  output logic               delayedValid,
  output logic               coincOut,
  output logic [COUNT_W-1:0] coincCount
);

  localparam int PTR_W = $clog2(DELAY);

  logic [PTR_W-1:0]  ptr;
  lineStrobes_t      strobes;
  logic [NUM_CH-1:0] rawIn;

  always_comb begin
    rawIn           = '0;
    rawIn[CH_DELAY] = delayChIn;
    rawIn[CH_LIVE]  = liveChIn;
  end

  delay_ctrl #(.DELAY(DELAY)) i_ctrl (
    .clk     (clk),
    .rst     (rst),
    .ptr     (ptr),
    .strobes (strobes)
  );

  delay_datapath #(.DELAY(DELAY), .COUNT_W(COUNT_W)) i_dp (
    .clk        (clk),
    .rst        (rst),
    .rawIn      (rawIn),
    .ptr        (ptr),
    .strobes    (strobes),
    .coincClr   (coincClr),
    .delayedOut (delayedOut),
    .coincOut   (coincOut),
    .coincCount (coincCount)
  );

  assign delayedValid = strobes.outValid;

endmodule

// File: rtl/period_delay_coinc_checker.sv
module period_delay_coinc_checker #(
  parameter int DELAY   = 2048,
  parameter int COUNT_W = 32
) (
  input logic               clk,
  input logic               rst,
  input logic               coincClr,
  input logic               delayedOut,
  input logic               delayedValid,
  input logic               coincOut,
  input logic [COUNT_W-1:0] coincCount
);

  localparam int CYC_W = $clog2(DELAY + 2) + 1;
  localparam logic [CYC_W-1:0]   CYC_LIM   = CYC_W'(DELAY + 1);
  localparam logic [COUNT_W-1:0] COUNT_MAX = {COUNT_W{1'b1}};

  // Edges since reset release, saturating at the fill point.
  logic [CYC_W-1:0] cycCnt;

  always_ff @(posedge clk) begin
    if (rst)                   cycCnt <= '0;
    else if (cycCnt != CYC_LIM) cycCnt <= cycCnt + 1'b1;
  end

  a_r5_valid_at_fill: assert property (@(posedge clk) disable iff (rst)
    delayedValid == (cycCnt == CYC_LIM));

  a_r5_valid_sticky: assert property (@(posedge clk) disable iff (rst)
    delayedValid |=> delayedValid);

  a_r6_quiet_before_valid: assert property (@(posedge clk) disable iff (rst)
    !delayedValid |-> (!delayedOut && !coincOut));

  a_r3_coinc_needs_delayed: assert property (@(posedge clk) disable iff (rst)
    coincOut |-> delayedOut);

  a_r9_clear: assert property (@(posedge clk) disable iff (rst)
    coincClr |=> coincCount == '0);

  a_r7_step_on_rise: assert property (@(posedge clk) disable iff (rst)
    ($rose(coincOut) && !coincClr && coincCount != COUNT_MAX)
      |=> coincCount == $past(coincCount) + COUNT_W'(1));

  a_r7_hold_otherwise: assert property (@(posedge clk) disable iff (rst)
    (!$rose(coincOut) && !coincClr) |=> $stable(coincCount));

  a_r8_no_wrap: assert property (@(posedge clk) disable iff (rst)
    (coincCount == COUNT_MAX && !coincClr) |=> coincCount == COUNT_MAX);

endmodule

bind period_delay_coinc period_delay_coinc_checker #(
  .DELAY(DELAY), .COUNT_W(COUNT_W)
) i_checker (
  .clk          (clk),
  .rst          (rst),
  .coincClr     (coincClr),
  .delayedOut   (delayedOut),
  .delayedValid (delayedValid),
  .coincOut     (coincOut),
  .coincCount   (coincCount)
);

// File: tb/test_period_delay_coinc.sv
`timescale 1ns/1ps
module test_period_delay_coinc;

  localparam int CLK_PERIOD = 20;
  localparam int TB_DELAY   = 16;
  localparam int TB_COUNT_W = 4;
  localparam int CNT_MAX    = (1 << TB_COUNT_W) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic delayChIn = 1'b0;
  logic liveChIn  = 1'b0;
  logic coincClr  = 1'b0;
  logic delayedOut, delayedValid, coincOut;
  logic [TB_COUNT_W-1:0] coincCount;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  bit sawSat = 0;

  bit delQ[$];
  bit liveQ[$];
  bit dHist[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  period_delay_coinc #(.DELAY(TB_DELAY), .COUNT_W(TB_COUNT_W)) i_period_delay_coinc (
    .clk(clk), .rst(rst), .delayChIn(delayChIn), .liveChIn(liveChIn),
    .coincClr(coincClr), .delayedOut(delayedOut), .delayedValid(delayedValid),
    .coincOut(coincOut), .coincCount(coincCount)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s at %0t: actual=%0d expected=%0d", tag, $time, act, exp);
    end
  endtask

  // Driver: sets inputs for the coming edge and queues the expected samples.
  task automatic driveCycle(bit d, bit l, bit c);
    delayChIn = d;
    liveChIn  = l;
    coincClr  = c;
    delQ.push_back(d);
    liveQ.push_back(l);
    dHist.push_back(d);
    @(negedge clk);
  endtask

  function automatic bit pastDelay();
    if (dHist.size() >= TB_DELAY) return dHist[dHist.size() - TB_DELAY];
    return 1'b0;
  endfunction

  // Monitor: one expected item per cycle, sampled a quarter period after the edge.
  initial begin
    int n = 0;
    int expCount = 0;
    bit ec1 = 0, ec2 = 0;
    wait (rst == 1'b0);
    while (!done) begin
      bit expValid, expDel, expLive, expCoinc;
      @(posedge clk);
      #(CLK_PERIOD/4);
      n++;
      expLive  = liveQ.pop_front();
      expValid = (n >= TB_DELAY + 1);
      expDel   = 1'b0;
      if (expValid) expDel = delQ.pop_front();
      expCoinc = expDel & expLive;
      // counter update of this edge uses coincidence of the two prior cycles
      if (coincClr) expCount = 0;
      else if (ec1 && !ec2 && expCount < CNT_MAX) expCount++;
      if (expCount == CNT_MAX) sawSat = 1;

      chk("R5 valid", delayedValid, expValid);
      if (!expValid) begin
        chk("R6 delayed quiet", delayedOut, 0);
        chk("R6 coinc quiet", coincOut, 0);
      end else begin
        chk(n > 3*TB_DELAY + 2 ? "R4 delayed after wrap" : "R2 delayed", delayedOut, expDel);
        chk("R3 coinc", coincOut, expCoinc);
      end
      chk(coincClr ? "R9 clear" : (expCount == CNT_MAX ? "R8 saturate" : "R7 count"),
          coincCount, expCount);
      ec2 = ec1;
      ec1 = expCoinc;
    end
  end

  // Stimulus
  initial begin
    // live and delay histories start with the synchronizer's reset zeros
    delQ.push_back(0); delQ.push_back(0);
    liveQ.push_back(0); liveQ.push_back(0);
    repeat (4) @(posedge clk);
    #(CLK_PERIOD/4);
    chk("R1 reset delayed", delayedOut, 0);
    chk("R1 reset valid", delayedValid, 0);
    chk("R1 reset coinc", coincOut, 0);
    chk("R1 reset count", coincCount, 0);
    @(negedge clk);
    rst = 1'b0;

    // dense random, spans the fill point
    for (int i = 0; i < 40; i++)
      driveCycle(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 1'b0);

    // sparse pulses, live correlated with the delayed stream, periodic clears
    for (int i = 0; i < 400; i++) begin
      bit d = ($urandom_range(0, 6) == 0);
      bit l = ($urandom_range(0, 3) != 0) ? pastDelay() : 1'($urandom_range(0, 1));
      driveCycle(d, l, (i % 97) == 50);
    end

    // steady high: one rise then no further increments
    for (int i = 0; i < 60; i++) driveCycle(1'b1, 1'b1, i == 0);

    // many rises without clears to reach saturation
    for (int i = 0; i < 400; i++)
      driveCycle(1'($urandom_range(0, 1)), pastDelay(), 1'b0);

    for (int i = 0; i < 3; i++) driveCycle(1'b0, 1'b0, 1'b0);
    done = 1;
    chk("R8 saturation reached", sawSat, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule